// File: doc/BRIEF.md
# Dual-target SPI register access master

This block is a memory-mapped serial master for two clock-distribution chips that share one serial clock and one data-out line. Each chip has its own chip select and its own data-in line. Software writes one command word that holds a read/write flag, a byte-count field, a 7-bit register address, a data byte and one select bit per chip. The block sends this as a single 24-bit frame to every chip whose select bit is set. The frame may go to one chip, to both, or to neither.

On a read, the byte that comes back from each selected chip is captured on its own line. The two bytes land in separate byte lanes of one receive register. The same register file also sets the serial clock rate with a 2-bit divider select. It drives an active-low reset for each chip and four general user reset lines. It reads back a 16-bit clock-module status input and a 32-bit user status input.

Software starts a frame by writing the command register. It then polls the busy flag, or watches the done pulse, before it reads the receive register.

Top module: `dual_spi_regmaster`

## Requirements
- R1: After reset the block is in this state:
  - both chip selects `spiCsN` are high, `spiSclk` is low and `xferBusy` is low;
  - `chipRstN` is 0 and `userReset` is 0;
  - registers 1, 2 and 3 read 0;
  - register 0 reads only the clock-module status in bits [31:16].
- R2: A frame carries 24 serial clocks, and `spiMosi` changes only while `spiSclk` is low. The bits go out most significant first, in this order:
  - command bit 23 (1 = read, 0 = write);
  - the two count bits [22:21], which are always zero in a sent frame;
  - six zero bits, whatever was written to command bits [20:15];
  - the address in bits [14:8];
  - the data byte in bits [7:0].
  
  Register 1 reads back `{6'b0, selects[25:24], rw, 2'b0, 6'b0, addr, data}`.
- R3: Serial clock timing works as follows:
  - the half period H is 2^divSel bus clocks, where divSel is config bits [1:0];
  - `spiSclk` idles low;
  - the first rising edge comes H cycles after the chip selects fall;
  - the chip selects rise H cycles after the last falling edge;
  - `xferBusy` is high for exactly 49*H cycles after the command write.
- R4: Command bit 24 selects the sample-clock chip (`spiCsN[0]`) and bit 25 selects the reference-clock chip (`spiCsN[1]`). A selected chip's select is low for the whole frame. An unselected chip's select stays high, including when the frame selects neither chip.
- R5: Each selected chip's reply is captured separately:
  - on a read frame, `spiMiso[0]` is sampled on the last 8 rising edges, most significant bit first, into register 2 bits [7:0];
  - `spiMiso[1]` is captured the same way into bits [15:8];
  - the lanes of unselected chips keep their old value, and so do both lanes after a write frame;
  - bits [31:16] of register 2 read 0.
- R6: A command written while `xferBusy` is high is ignored. The running frame is not changed, the command readback keeps its old value, and no second frame follows.
- R7: A command whose count field [22:21] is not zero is ignored. No frame starts, and the command readback keeps its old value.
- R8: Config register 0:
  - bit 4 drives `chipRstN[0]` and bit 5 drives `chipRstN[1]`;
  - it reads back divSel in bits [1:0], the two reset bits, busy in bit 8, and `clkModStatus` in bits [31:16].
- R9: Register 3 bits [3:0] drive `userReset` and read back. Register 4 reads `userStatus`. Addresses 5 to 7 read 0.
- R10: `xferDone` pulses high for exactly one cycle, in the first cycle in which `xferBusy` is low after a frame.
- R11: The divider select is taken when the frame starts. A config write during a frame does not change that frame's timing, but it does apply to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| clkModStatus | input | 16 | Clock-module status, read in config [31:16] |
| userStatus | input | 32 | User status, read at register 4 |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out, shared by both chips |
| spiMiso | input | 2 | Serial data in; bit 0 sample chip, bit 1 reference chip |
| spiCsN | output | 2 | Active-low chip selects; bit 0 sample chip, bit 1 reference chip |
| chipRstN | output | 2 | Active-low chip resets |
| userReset | output | 4 | User reset lines |
| xferBusy | output | 1 | Frame in progress |
| xferDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
Frames are swept over all four divider settings, all four chip-select combinations and both directions. The sweep checks that the frame timing scales with H, and that each select only reaches its own chip. Each chip returns a different reply byte. This shows whether the lanes are swapped, and whether a lane is written when it is unselected or on a write. Some command writes and config writes happen in the middle of a frame. These separate a design that ignores such writes from one that restarts the frame, changes its rate or replaces the command. A command with a nonzero count checks that the block rejects it.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int NSLV         = 2;
  localparam int REG_W        = 32;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = 7;
  localparam int PAD_W        = 6;
  localparam int CNT_W        = 2;
  localparam int FRAME_W      = 1 + CNT_W + PAD_W + ADDR_W + DATA_W;
  localparam int ADDR_LSB     = DATA_W;
  localparam int PAD_LSB      = ADDR_LSB + ADDR_W;
  localparam int CNT_LSB      = PAD_LSB + PAD_W;
  localparam int RW_BIT       = CNT_LSB + CNT_W;
  localparam int SEL_LSB      = RW_BIT + 1;
  localparam int HALF_LAST    = 2 * FRAME_W;
  localparam int SAMPLE_FIRST = 2 * (FRAME_W - DATA_W);
  localparam int HALF_W       = $clog2(HALF_LAST + 1);
  localparam int CFG_RST_LSB  = 4;
  localparam int CFG_BUSY_BIT = 8;
  localparam int CFG_STAT_LSB = 16;

  localparam logic [2:0] RA_CFG   = 3'd0;
  localparam logic [2:0] RA_CMD   = 3'd1;
  localparam logic [2:0] RA_RX    = 3'd2;
  localparam logic [2:0] RA_URST  = 3'd3;
  localparam logic [2:0] RA_USTAT = 3'd4;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic finish;
  } xferStrobes_t;
endpackage

// File: rtl/dspi_divider.sv
module dspi_divider #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divSel,
  output logic             tick
);
  localparam int DC_W = (1 << DIV_W) - 1;

  logic [DC_W-1:0] divCnt;
  logic [DC_W:0]   halfLen;

  always_comb begin
    halfLen = (DC_W + 1)'(1) << divSel;
    tick    = run && ({1'b0, divCnt} == (halfLen - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rstN)            divCnt <= '0;
    else if (!run || tick) divCnt <= '0;
    else                  divCnt <= divCnt + 1'b1;
  end

  // R3: the half-period counter never passes its limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    run |-> ({1'b0, divCnt} < halfLen));
endmodule

// File: rtl/dspi_ctrl.sv
module dspi_ctrl
  import dspi_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrReq,
  input  logic             cmdCountZero,
  input  logic [DIV_W-1:0] divSelCfg,
  output xferStrobes_t     strobes,
  output logic             busy,
  output logic             sclk,
  output logic             done
);
  logic [HALF_W-1:0] halfCnt;
  logic [DIV_W-1:0]  divLatched;
  logic              tick;

  dspi_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rstN   (rstN),
    .run    (busy),
    .divSel (divLatched),
    .tick   (tick)
  );

  always_comb begin
    strobes.load     = cmdWrReq && !busy && cmdCountZero;
    strobes.shiftOut = tick && halfCnt[0];
    strobes.sampleIn = tick && !halfCnt[0] &&
                       (halfCnt >= HALF_W'(SAMPLE_FIRST)) &&
                       (halfCnt <  HALF_W'(HALF_LAST));
    strobes.finish   = tick && (halfCnt == HALF_W'(HALF_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      halfCnt    <= '0;
      divLatched <= '0;
      done       <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.load) begin
        busy       <= 1'b1;
        halfCnt    <= '0;
        divLatched <= divSelCfg;
      end else if (strobes.finish) begin
        busy    <= 1'b0;
        halfCnt <= '0;
      end else if (tick) begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign sclk = busy && halfCnt[0];

  // R3: the serial clock only moves on a divider tick
  a_r3_sclk_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> $stable(sclk));
  // R3: the half-period index stays within the frame
  a_r3_half_range: assert property (@(posedge clk) disable iff (!rstN)
    halfCnt <= HALF_W'(HALF_LAST));
  // R10: done lasts one cycle and marks the end of busy
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_done_end: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  // R11: the rate chosen at start holds through the frame
  a_r11_div_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(divLatched));
endmodule

// File: rtl/dspi_datapath.sv
module dspi_datapath
  import dspi_pkg::*;
#(
  parameter int DIV_W       = 2,
  parameter int USER_RST_W  = 4,
  parameter int USER_STAT_W = 32,
  parameter int CMOD_W      = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [2:0]             regAddr,
  input  logic [REG_W-1:0]       regWrData,
  output logic [REG_W-1:0]       regRdData,
  input  logic [CMOD_W-1:0]      clkModStatus,
  input  logic [USER_STAT_W-1:0] userStatus,
  input  xferStrobes_t           strobes,
  input  logic                   busy,
  input  logic [NSLV-1:0]        spiMiso,
  output logic                   spiMosi,
  output logic [NSLV-1:0]        slvSel,
  output logic                   cmdWrReq,
  output logic                   cmdCountZero,
  output logic [DIV_W-1:0]       divSel,
  output logic [NSLV-1:0]        chipRstN,
  output logic [USER_RST_W-1:0]  userReset
);
  logic                cmdRw;
  logic [ADDR_W-1:0]   cmdAddr;
  logic [DATA_W-1:0]   cmdData;
  logic [FRAME_W-1:0]  shiftReg;
  logic [FRAME_W-1:0]  loadFrame;
  logic [DATA_W-1:0]   rxShift [NSLV];
  logic [DATA_W-1:0]   rxLane  [NSLV];
  logic [REG_W-1:0]    cfgWord;
  logic [REG_W-1:0]    cmdWord;
  logic [REG_W-1:0]    rxWord;

  assign cmdWrReq     = regWr && (regAddr == RA_CMD);
  assign cmdCountZero = (regWrData[CNT_LSB +: CNT_W] == '0);
  assign loadFrame    = {regWrData[RW_BIT], {CNT_W{1'b0}}, {PAD_W{1'b0}},
                         regWrData[ADDR_LSB +: ADDR_W], regWrData[DATA_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divSel    <= '0;
      chipRstN  <= '0;
      userReset <= '0;
    end else if (regWr) begin
      if (regAddr == RA_CFG) begin
        divSel   <= regWrData[DIV_W-1:0];
        chipRstN <= regWrData[CFG_RST_LSB +: NSLV];
      end
      if (regAddr == RA_URST) userReset <= regWrData[USER_RST_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdRw    <= 1'b0;
      cmdAddr  <= '0;
      cmdData  <= '0;
      slvSel   <= '0;
      shiftReg <= '0;
    end else if (strobes.load) begin
      cmdRw    <= regWrData[RW_BIT];
      cmdAddr  <= regWrData[ADDR_LSB +: ADDR_W];
      cmdData  <= regWrData[DATA_W-1:0];
      slvSel   <= regWrData[SEL_LSB +: NSLV];
      shiftReg <= loadFrame;
    end else if (strobes.shiftOut) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign spiMosi = shiftReg[FRAME_W-1];

  for (genvar i = 0; i < NSLV; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxShift[i] <= '0;
        rxLane[i]  <= '0;
      end else begin
        if (strobes.sampleIn) rxShift[i] <= {rxShift[i][DATA_W-2:0], spiMiso[i]};
        if (strobes.finish && cmdRw && slvSel[i]) rxLane[i] <= rxShift[i];
      end
    end
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[DIV_W-1:0]              = divSel;
    cfgWord[CFG_RST_LSB +: NSLV]    = chipRstN;
    cfgWord[CFG_BUSY_BIT]           = busy;
    cfgWord[CFG_STAT_LSB +: CMOD_W] = clkModStatus;
    cmdWord = '0;
    cmdWord[SEL_LSB +: NSLV]        = slvSel;
    cmdWord[RW_BIT]                 = cmdRw;
    cmdWord[ADDR_LSB +: ADDR_W]     = cmdAddr;
    cmdWord[DATA_W-1:0]             = cmdData;
    rxWord = '0;
    for (int i = 0; i < NSLV; i++) rxWord[i*DATA_W +: DATA_W] = rxLane[i];
    case (regAddr)
      RA_CFG:   regRdData = cfgWord;
      RA_CMD:   regRdData = cmdWord;
      RA_RX:    regRdData = rxWord;
      RA_URST:  regRdData = REG_W'(userReset);
      RA_USTAT: regRdData = REG_W'(userStatus);
      default:  regRdData = '0;
    endcase
  end

  // R6: the stored command cannot change while a frame runs
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(cmdWord) && $stable(slvSel)));
  // R5: a write frame leaves the receive lanes alone
  a_r5_write_keeps_rx: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && !cmdRw) |=> $stable(rxWord));
endmodule

// File: rtl/dual_spi_regmaster.sv
module dual_spi_regmaster
  import dspi_pkg::*;
#(
  parameter int DIV_W       = 2,
  parameter int USER_RST_W  = 4,
  parameter int USER_STAT_W = 32,
  parameter int CMOD_W      = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [2:0]             regAddr,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic [CMOD_W-1:0]      clkModStatus,
  input  logic [USER_STAT_W-1:0] userStatus,
  output logic                   spiSclk,
  output logic                   spiMosi,
  input  logic [1:0]             spiMiso,
  output logic [1:0]             spiCsN,
  output logic [1:0]             chipRstN,
  output logic [USER_RST_W-1:0]  userReset,
  output logic                   xferBusy,
  output logic                   xferDone
);
  xferStrobes_t     strobes;
  logic [NSLV-1:0]  slvSel;
  logic             cmdWrReq;
  logic             cmdCountZero;
  logic [DIV_W-1:0] divSel;

  dspi_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdWrReq     (cmdWrReq),
    .cmdCountZero (cmdCountZero),
    .divSelCfg    (divSel),
    .strobes      (strobes),
    .busy         (xferBusy),
    .sclk         (spiSclk),
    .done         (xferDone)
  );

  dspi_datapath #(
    .DIV_W       (DIV_W),
    .USER_RST_W  (USER_RST_W),
    .USER_STAT_W (USER_STAT_W),
    .CMOD_W      (CMOD_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .regWr        (regWr),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .clkModStatus (clkModStatus),
    .userStatus   (userStatus),
    .strobes      (strobes),
    .busy         (xferBusy),
    .spiMiso      (spiMiso),
    .spiMosi      (spiMosi),
    .slvSel       (slvSel),
    .cmdWrReq     (cmdWrReq),
    .cmdCountZero (cmdCountZero),
    .divSel       (divSel),
    .chipRstN     (chipRstN),
    .userReset    (userReset)
  );

  assign spiCsN = ~({NSLV{xferBusy}} & slvSel);

  // R2: data out holds while the serial clock is high
  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi));
  // R4: selects do not move inside a frame
  a_r4_cs_steady: assert property (@(posedge clk) disable iff (!rstN)
    (xferBusy && $past(xferBusy)) |-> $stable(spiCsN));
  // R3: the serial clock is low whenever no frame runs
  a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!xferBusy && !$past(xferBusy)) |-> !spiSclk);
endmodule

// File: tb/tb_dual_spi_regmaster.sv
module tb_dual_spi_regmaster;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] clkModStatus = 16'hBEEF;
  logic [31:0] userStatus = 32'hA5C3_1E0F;
  logic        spiSclk, spiMosi;
  logic [1:0]  spiMiso = 2'b00;
  logic [1:0]  spiCsN, chipRstN;
  logic [3:0]  userReset;
  logic        xferBusy, xferDone;

  always #4 clk = ~clk;

  dual_spi_regmaster dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .clkModStatus(clkModStatus), .userStatus(userStatus),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .spiCsN(spiCsN), .chipRstN(chipRstN), .userReset(userReset),
    .xferBusy(xferBusy), .xferDone(xferDone)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // bench-side monitor and two slave models, all sampled on the falling clock
  int        cyc = 0;
  logic      prevSclk = 0, prevBusy = 0, prevAnyCs = 0;
  int        rises = 0, doneCnt = 0;
  bit        doneOk = 1;
  logic [23:0] frameBits = '0;
  logic [1:0]  csSeen = '0;
  int        tCsFall = 0, tFirstRise = 0, tLastFall = 0, tCsRise = 0;
  logic [7:0] resp [2];

  always @(negedge clk) begin
    cyc++;
    if (xferBusy && !prevBusy) begin
      rises = 0; frameBits = '0; csSeen = '0; doneCnt = 0; doneOk = 1;
    end
    if (spiSclk && !prevSclk) begin
      if (rises == 0) tFirstRise = cyc;
      frameBits = {frameBits[22:0], spiMosi};
      rises++;
    end
    if (!spiSclk && prevSclk) begin
      tLastFall = cyc;
      if (rises >= 16 && rises < 24)
        for (int i = 0; i < 2; i++) spiMiso[i] = resp[i][23 - rises];
    end
    if ((spiCsN != 2'b11) && !prevAnyCs) tCsFall = cyc;
    if ((spiCsN == 2'b11) && prevAnyCs)  tCsRise = cyc;
    csSeen |= ~spiCsN;
    if (xferDone) begin
      doneCnt++;
      if (xferBusy) doneOk = 0;
    end
    prevSclk  = spiSclk;
    prevBusy  = xferBusy;
    prevAnyCs = (spiCsN != 2'b11);
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  logic [7:0] laneExp [2] = '{8'h00, 8'h00};
  logic [31:0] lastCmd = '0;

  // midKind: 0 none, 1 command write in the middle, 2 config write in the middle
  task automatic runFrame(input int div, input bit rw, input logic [1:0] sel,
                          input logic [6:0] addr, input logic [7:0] data,
                          input logic [7:0] r0, input logic [7:0] r1,
                          input int midKind, input logic [31:0] midData);
    logic [31:0] cmd, rdv;
    logic [23:0] expFrame;
    int n, h;
    bit busyBitSeen;
    h = 1 << div;
    resp[0] = r0; resp[1] = r1;
    wr(3'd0, 32'h30 | 32'(div));
    cmd = {6'b0, sel, rw, 2'b00, 6'h2A, addr, data};
    expFrame = {rw, 2'b00, 6'b0, addr, data};
    wr(3'd1, cmd);
    n = 0; busyBitSeen = 0;
    while (xferBusy && n < 5000) begin
      if (midKind == 1 && n == 5) begin regWr = 1; regAddr = 3'd1; regWrData = midData; end
      if (midKind == 2 && n == 5) begin regWr = 1; regAddr = 3'd0; regWrData = midData; end
      if (n == 6) regWr = 0;
      if (n == 20) begin regAddr = 3'd0; #1 busyBitSeen = regRdData[8]; end
      n++;
      @(negedge clk);
    end
    chk(n == 49 * h, "R3", "busy cycles", n, 49 * h);
    if (midKind == 2) chk(n == 49 * h, "R11", "rate kept after mid config write", n, 49 * h);
    chk(busyBitSeen, "R8", "config busy bit mid frame", busyBitSeen, 1);
    repeat (3) @(negedge clk);
    chk(rises == 24, "R2", "serial clock count", rises, 24);
    if (midKind == 1) chk(rises == 24 && !xferBusy, "R6", "no second frame", rises, 24);
    chk(frameBits == expFrame, "R2", "frame bits", frameBits, expFrame);
    if (sel != 0) begin
      chk(tFirstRise - tCsFall == h, "R3", "select lead", tFirstRise - tCsFall, h);
      chk(tCsRise - tLastFall == h, "R3", "select trail", tCsRise - tLastFall, h);
    end
    chk(csSeen == sel, "R4", "selects asserted", csSeen, sel);
    chk(doneCnt == 1 && doneOk, "R10", "done pulse", doneCnt, 1);
    if (rw) for (int i = 0; i < 2; i++) if (sel[i]) laneExp[i] = resp[i];
    rd(3'd2, rdv);
    chk(rdv == {16'h0, laneExp[1], laneExp[0]}, "R5", "receive lanes", rdv,
        {16'h0, laneExp[1], laneExp[0]});
    rd(3'd1, rdv);
    lastCmd = {6'b0, sel, rw, 2'b00, 6'b0, addr, data};
    chk(rdv == lastCmd, midKind == 1 ? "R6" : "R2", "command readback", rdv, lastCmd);
    rd(3'd0, rdv);
    chk(rdv[8] == 1'b0, "R8", "busy bit after frame", rdv[8], 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    resp[0] = 8'h00; resp[1] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spiCsN == 2'b11 && !spiSclk && !xferBusy, "R1", "idle pins",
        {spiCsN, spiSclk, xferBusy}, 4'b1100);
    chk(chipRstN == 2'b00 && userReset == 4'h0, "R1", "reset outputs",
        {chipRstN, userReset}, 0);
    rd(3'd0, v); chk(v == 32'hBEEF_0000, "R1", "config after reset", v, 32'hBEEF_0000);
    rd(3'd1, v); chk(v == 0, "R1", "command after reset", v, 0);
    rd(3'd2, v); chk(v == 0, "R1", "receive after reset", v, 0);
    rd(3'd3, v); chk(v == 0, "R1", "user reset after reset", v, 0);

    // R8 chip resets and config readback
    wr(3'd0, 32'h0000_0022);
    chk(chipRstN == 2'b10, "R8", "chip reset outputs", chipRstN, 2'b10);
    rd(3'd0, v); chk(v == 32'hBEEF_0022, "R8", "config readback", v, 32'hBEEF_0022);

    // R9 user registers and unmapped addresses
    wr(3'd3, 32'hFFFF_FFF5);
    chk(userReset == 4'h5, "R9", "user reset outputs", userReset, 4'h5);
    rd(3'd3, v); chk(v == 32'h5, "R9", "user reset readback", v, 32'h5);
    rd(3'd4, v); chk(v == 32'hA5C3_1E0F, "R9", "user status", v, 32'hA5C3_1E0F);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); chk(v == 0, "R9", "unmapped read", v, 0);
    end

    // sweep: divider x selects x direction (R2 R3 R4 R5 R10)
    for (int div = 0; div < 4; div++)
      for (int sel = 0; sel < 4; sel++)
        for (int rw = 0; rw < 2; rw++) begin
          int k;
          k = div * 8 + sel * 2 + rw;
          runFrame(div, rw[0], sel[1:0], 7'(k * 5 + 3), 8'(k * 29 + 7),
                   8'(8'h3C ^ (k * 37)), 8'(8'hA5 + k * 11), 0, 0);
        end

    // R6 command written mid frame is ignored
    runFrame(1, 1'b1, 2'b11, 7'h55, 8'hC3, 8'h81, 8'h7E, 1,
             {6'b0, 2'b01, 1'b0, 2'b00, 6'b0, 7'h12, 8'h34});

    // R11 config written mid frame does not change that frame, applies next
    runFrame(0, 1'b0, 2'b01, 7'h0F, 8'hF0, 8'h00, 8'h00, 2, 32'h0000_0033);
    rd(3'd0, v); chk(v[1:0] == 2'd3, "R11", "new divider stored", v[1:0], 3);

    // R7 nonzero count field is rejected
    wr(3'd1, {6'b0, 2'b11, 1'b1, 2'b01, 6'b0, 7'h44, 8'h99});
    chk(!xferBusy, "R7", "no busy after bad count", xferBusy, 0);
    repeat (20) @(negedge clk);
    chk(!xferBusy && spiCsN == 2'b11 && !spiSclk, "R7", "bus idle after bad count",
        {xferBusy, spiCsN, spiSclk}, 4'b0110);
    rd(3'd1, v); chk(v == lastCmd, "R7", "command readback kept", v, lastCmd);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule